// File: doc/BRIEF.md
# Serial Configuration Stream Deframer

This block sits at the front of a serially configured device that can be one link in a chain of such devices. It watches a one-bit configuration stream that is sampled on the rising edge of the configuration clock. First it looks for a start pattern: a run of idle ones and then the code `0010`. A 24-bit total length follows the pattern. The block then takes in a fixed number of framed records for its own configuration memory. Each record goes out on a simple write port as a frame index and a data word.

Everything the block does not keep for itself goes out on a data-out pin toward the next device in the chain. That covers the idle ones, the start pattern, the length field and any frames left over once its own memory is full. While the block is filling its own memory, data-out is held High. A running count of configuration clocks is compared with the captured length. When the memory is full and the two values are equal, the block raises a start-up request and stops taking in data. A malformed record sets a framing-error flag that stays set, and the block goes back to searching for a start pattern.

Top module: `cfg_stream_deframer`

## Requirements
- R1: After reset, and while the block is searching for a start pattern, every bit sampled at a rising edge appears on `dout` at the next falling edge.
- R2: A start is recognised when the last eight sampled bits are `1111_0010`, oldest bit first. The next LEN_W bits, sent most significant bit first, form the length. These bits are also forwarded on `dout` at the next falling edge, as in R1.
- R3: From the first bit after the length until the bit that completes the last own frame, `dout` is 1 whatever is on `din`.
- R4: A frame is one start bit of 0, then DATA_W data bits, then three stop bits of 1. Ones that arrive before the start bit of frame 0 are skipped. In `wr_data`, the first data bit received is the most significant bit.
- R5: A valid frame is written with `wr_en` High for exactly one cycle. This happens in the cycle after the rising edge that samples its third stop bit. `wr_idx` counts from 0 in arrival order.
- R6: A start bit of 1 in any frame after frame 0, or a stop bit of 0, sets `frame_err`. That frame is not written, and the block returns to searching for a start pattern. `frame_err` stays set until reset.
- R7: The clock count is 8 at the edge that samples the final start-pattern bit, and it goes up by one at every later edge. After the first edge at which the memory is full and the count equals the length, `startup_req` is 1, and it stays 1 until reset.
- R8: After the last own frame and before the start-up request, each sampled bit is forwarded to `dout` at the next falling edge.
- R9: Once `startup_req` is 1, `dout` stays 1 and there are no further writes.
- R10: While `rst_n` is low, `startup_req`, `frame_err` and `wr_en` are 0 and `dout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial configuration data in, sampled on the rising edge |
| dout | output | 1 | Serial data toward the next device, changes on the falling edge |
| wr_en | output | 1 | One-cycle frame write strobe |
| wr_idx | output | IDX_W | Index of the frame being written |
| wr_data | output | DATA_W | Data field of the frame being written |
| startup_req | output | 1 | Request to begin start-up, held until reset |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions rely on a few properties of the stream. Consecutive completed frames are at least DATA_W+4 clocks apart. Reset is held low through the first clock edge. Once the start-up request has risen, nothing on `din` can clear it or the error flag. The bench drives `din` only at falling edges and holds reset from time zero. It sends only streams built from the frame format, so any strobe spacing comes from whole frames. Corrupted frames are made by flipping a single start bit or stop bit. That keeps every error case inside the record layout the checker expects.

// File: rtl/cfgd_pkg.sv
// Shared definitions for the configuration stream deframer.
// Holds the sequencing states and the start-pattern constant.
package cfgd_pkg;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,   // searching for the start pattern
        ST_LEN   = 3'd1,   // shifting in the length field
        ST_LOAD  = 3'd2,   // taking in own frames
        ST_SPILL = 3'd3,   // memory full, forwarding surplus bits
        ST_DONE  = 3'd4    // start-up requested
    } cfgd_state_t;

    localparam int               SYNC_BITS    = 8;
    localparam logic [SYNC_BITS-1:0] SYNC_PATTERN = 8'b1111_0010;

endpackage

// File: rtl/cfgd_sync_hunt.sv
// Start-pattern detector.
// Keeps a history of the last PAT_W bits while enabled and flags the bit that
// completes PATTERN. Assumes: flush is held whenever the search is not active,
// so every new search starts from an empty history.
module cfgd_sync_hunt #(
    parameter int               PAT_W   = 8,
    parameter logic [PAT_W-1:0] PATTERN = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic flush,
    input  logic bit_in,
    output logic hit
);

    logic [PAT_W-1:0] hist;
    logic [PAT_W-1:0] hist_next;

    // Candidate history including the bit present at this edge.
    always_comb begin
        hist_next = {hist[PAT_W-2:0], bit_in};
        hit       = en && (hist_next == PATTERN);
    end

    // Shift the history while searching, empty it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist <= '0;
        end else if (en) begin
            hist <= hist_next;
        end
    end

endmodule

// File: rtl/cfgd_frame_rx.sv
// Frame receiver for the own-memory phase.
// Walks the start/data/stop layout of each record and gathers the data field
// (first bit ends in the MSB). It reports a bad start or stop bit, and it
// strobes the completed record out one cycle after its last stop bit.
// Assumes: restart is held while the own-memory phase is not active.
module cfgd_frame_rx #(
    parameter int DATA_W = 71,
    parameter int FRAMES = 197,
    parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              bit_in,
    output logic              bad,
    output logic              last_done,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    localparam int POS_W = $clog2(DATA_W + 4);
    localparam logic [POS_W-1:0] POS_LAST_DATA = POS_W'(DATA_W);
    localparam logic [POS_W-1:0] POS_LAST_STOP = POS_W'(DATA_W + 3);
    localparam logic [IDX_W-1:0] IDX_FINAL     = IDX_W'(FRAMES - 1);

    logic [POS_W-1:0]  pos;
    logic [IDX_W-1:0]  fcnt;
    logic [DATA_W-1:0] shreg;
    logic              at_start, at_stop, at_data, skip, done_now;

    // Decode the position of the current bit inside the record.
    always_comb begin
        at_start  = (pos == '0);
        at_data   = !at_start && (pos <= POS_LAST_DATA);
        at_stop   = (pos > POS_LAST_DATA);
        skip      = en && at_start && (fcnt == '0) && bit_in;
        bad       = en && ((at_start && bit_in && (fcnt != '0)) ||
                           (at_stop && !bit_in));
        done_now  = en && (pos == POS_LAST_STOP) && bit_in;
        last_done = done_now && (fcnt == IDX_FINAL);
    end

    // Advance the bit position and frame count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos  <= '0;
            fcnt <= '0;
        end else if (en && !skip && !bad) begin
            pos <= done_now ? '0 : pos + POS_W'(1);
            if (done_now) begin
                fcnt <= fcnt + IDX_W'(1);
            end
        end
    end

    // Gather the data field, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (en && at_data) begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
        end
    end

    // Present a completed record for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= done_now;
            if (done_now) begin
                wr_idx  <= fcnt;
                wr_data <= shreg;
            end
        end
    end

endmodule

// File: rtl/cfgd_clk_tally.sv
// Configuration clock counter.
// Loads the start-pattern length when a start is recognised and then counts
// every edge while the stream is active. Assumes: load and run never clash
// (load happens only while searching, run only after).
module cfgd_clk_tally #(
    parameter int CNT_W    = 24,
    parameter int LOAD_VAL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    // Load on a recognised start, otherwise count active edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= CNT_W'(LOAD_VAL);
        end else if (run) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cfgd_dout_stage.sv
// Data-out stage.
// Picks the forwarded bit or a constant 1 on the rising edge and launches it
// on the falling edge, so the next device samples it half a clock later.
// Assumes: fwd reflects the sequencing state before the current edge.
module cfgd_dout_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd,
    input  logic bit_in,
    output logic dout
);

    logic held;

    // Capture the outgoing value on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b1;
        end else begin
            held <= fwd ? bit_in : 1'b1;
        end
    end

    // Launch it on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
        end else begin
            dout <= held;
        end
    end

endmodule

// File: rtl/cfg_stream_deframer.sv
// Serial configuration stream deframer (top).
// Sequences search, length capture, own-frame loading, surplus forwarding and
// the start-up request. Assumes: din is stable around each rising edge of
// cclk, and rst_n is synchronous to cclk.
module cfg_stream_deframer
    import cfgd_pkg::*;
#(
    parameter  int DATA_W = 71,
    parameter  int FRAMES = 197,
    parameter  int LEN_W  = 24,
    localparam int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic              cclk,
    input  logic              rst_n,
    input  logic              din,
    output logic              dout,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              startup_req,
    output logic              frame_err
);

    localparam int LPOS_W = $clog2(LEN_W + 1);
    localparam logic [LPOS_W-1:0] LPOS_LAST = LPOS_W'(LEN_W - 1);

    cfgd_state_t       state;
    logic              sync_hit, rx_bad, rx_last;
    logic              in_hunt, in_len, in_load, in_spill, fwd, cnt_run;
    logic [LEN_W-1:0]  len_q, clk_cnt, cnt_next;
    logic [LPOS_W-1:0] len_pos;
    logic              len_match;

    // State decodes shared by the submodules.
    always_comb begin
        in_hunt   = (state == ST_HUNT);
        in_len    = (state == ST_LEN);
        in_load   = (state == ST_LOAD);
        in_spill  = (state == ST_SPILL);
        fwd       = in_hunt || in_len || in_spill;
        cnt_run   = in_len || in_load || in_spill;
        cnt_next  = clk_cnt + LEN_W'(1);
        len_match = (cnt_next == len_q);
    end

    cfgd_sync_hunt #(
        .PAT_W   (SYNC_BITS),
        .PATTERN (SYNC_PATTERN)
    ) u_hunt (
        .clk    (cclk),
        .rst_n  (rst_n),
        .en     (in_hunt),
        .flush  (!in_hunt),
        .bit_in (din),
        .hit    (sync_hit)
    );

    cfgd_frame_rx #(
        .DATA_W (DATA_W),
        .FRAMES (FRAMES),
        .IDX_W  (IDX_W)
    ) u_rx (
        .clk       (cclk),
        .rst_n     (rst_n),
        .en        (in_load),
        .restart   (!in_load),
        .bit_in    (din),
        .bad       (rx_bad),
        .last_done (rx_last),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfgd_clk_tally #(
        .CNT_W    (LEN_W),
        .LOAD_VAL (SYNC_BITS)
    ) u_tally (
        .clk   (cclk),
        .rst_n (rst_n),
        .load  (sync_hit),
        .run   (cnt_run),
        .count (clk_cnt)
    );

    cfgd_dout_stage u_out (
        .clk    (cclk),
        .rst_n  (rst_n),
        .fwd    (fwd),
        .bit_in (din),
        .dout   (dout)
    );

    // Main sequencer.
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            case (state)
                ST_HUNT:  if (sync_hit) state <= ST_LEN;
                ST_LEN:   if (len_pos == LPOS_LAST) state <= ST_LOAD;
                ST_LOAD: begin
                    if (rx_bad) begin
                        state <= ST_HUNT;
                    end else if (rx_last) begin
                        state <= len_match ? ST_DONE : ST_SPILL;
                    end
                end
                ST_SPILL: if (len_match) state <= ST_DONE;
                default:  state <= state;
            endcase
        end
    end

    // Length field capture, MSB first.
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            len_q   <= '0;
            len_pos <= '0;
        end else if (in_len) begin
            len_q   <= {len_q[LEN_W-2:0], din};
            len_pos <= (len_pos == LPOS_LAST) ? '0 : len_pos + LPOS_W'(1);
        end else begin
            len_pos <= '0;
        end
    end

    // Sticky framing error.
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
        end else if (rx_bad) begin
            frame_err <= 1'b1;
        end
    end

    assign startup_req = (state == ST_DONE);

endmodule

// File: rtl/cfgd_checker.sv
// Property checker for the deframer, attached to every instance by bind.
// Watches only the top-level ports.
module cfgd_checker (
    input logic clk,
    input logic rst_n,
    input logic dout,
    input logic wr_en,
    input logic startup_req,
    input logic frame_err
);

    // Records are several clocks long, so a strobe never repeats at once.
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // Once raised, the error flag stays up.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    // Once raised, the start-up request stays up.
    assert_startup_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        startup_req |=> startup_req);

    // After start-up: data-out idles high and no further writes occur.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        startup_req |=> (dout && !wr_en));

    // Reset clears the flags and the strobe.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!startup_req && !frame_err && !wr_en));

endmodule

bind cfg_stream_deframer cfgd_checker u_cfgd_checker (
    .clk         (cclk),
    .rst_n       (rst_n),
    .dout        (dout),
    .wr_en       (wr_en),
    .startup_req (startup_req),
    .frame_err   (frame_err)
);

// File: tb/tb_cfg_stream_deframer.sv
module tb_cfg_stream_deframer;

    localparam int DW = 8;
    localparam int FR = 3;
    localparam int IW = 2;

    logic          cclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b1;
    logic          dout, wr_en, startup_req, frame_err;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state (0 hunt, 1 length, 2 load, 3 spill, 4 done)
    int mst, hist, mcnt, lenv, lbits, pos, fi, word;
    int e_str, e_idx, e_data, e_err, e_dout;
    string dout_tag;

    cfg_stream_deframer #(.DATA_W(DW), .FRAMES(FR), .LEN_W(24)) dut (
        .cclk(cclk), .rst_n(rst_n), .din(din), .dout(dout),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .startup_req(startup_req), .frame_err(frame_err)
    );

    always #5 cclk = ~cclk;

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        mst = 0; hist = 0; mcnt = 0; lenv = 0; lbits = 0; pos = 0; fi = 0;
        word = 0; e_str = 0; e_idx = 0; e_data = 0; e_err = 0; e_dout = 1;
        dout_tag = "R1 dout";
    endtask

    // Behavioural step of the reference for one sampled bit.
    task automatic model_step(input int b);
        e_dout = (mst == 0 || mst == 1 || mst == 3) ? b : 1;
        case (mst)
            0: dout_tag = "R1 dout";
            1: dout_tag = "R2 dout";
            2: dout_tag = "R3 dout";
            3: dout_tag = "R8 dout";
            default: dout_tag = "R9 dout";
        endcase
        e_str = 0;
        case (mst)
            0: begin
                hist = ((hist << 1) | b) & 255;
                if (hist == 'hF2) begin
                    mst = 1; mcnt = 8; lenv = 0; lbits = 0; hist = 0;
                end
            end
            1: begin
                mcnt++;
                lenv = (lenv << 1) | b;
                lbits++;
                if (lbits == 24) begin mst = 2; pos = 0; fi = 0; end
            end
            2: begin
                mcnt++;
                if (pos == 0) begin
                    if (b == 1) begin
                        if (fi != 0) begin e_err = 1; mst = 0; hist = 0; end
                    end else begin
                        pos = 1; word = 0;
                    end
                end else if (pos <= DW) begin
                    word = ((word << 1) | b) & ((1 << DW) - 1);
                    pos++;
                end else if (b == 0) begin
                    e_err = 1; mst = 0; hist = 0;
                end else if (pos == DW + 3) begin
                    e_str = 1; e_idx = fi; e_data = word;
                    fi++; pos = 0;
                    if (fi == FR) mst = (mcnt == lenv) ? 4 : 3;
                end else begin
                    pos++;
                end
            end
            3: begin
                mcnt++;
                if (mcnt == lenv) mst = 4;
            end
            default: ;
        endcase
    endtask

    // Drive one bit at the falling edge and compare after both edges.
    task automatic send(input int b);
        string t;
        @(negedge cclk);
        #1;
        chk(dout_tag, dout, e_dout);
        din = b[0];
        @(posedge cclk);
        #1;
        model_step(b);
        chk("R5 strobe", wr_en, e_str);
        if (e_str == 1) begin
            chk("R5 index", wr_idx, e_idx);
            chk("R4 data", wr_data, e_data);
        end
        chk("R6 error", frame_err, e_err);
        chk("R7 startup", startup_req, (mst == 4) ? 1 : 0);
        t = "";
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din = 1'b1;
        repeat (3) @(posedge cclk);
        #1;
        model_reset();
        chk("R10 dout", dout, 1);
        chk("R10 strobe", wr_en, 0);
        chk("R10 error", frame_err, 0);
        chk("R10 startup", startup_req, 0);
        rst_n = 1'b1;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send(1);
    endtask

    task automatic send_header(input int len);
        send_ones(8);
        send(0); send(0); send(1); send(0);
        for (int i = 23; i >= 0; i--) send((len >> i) & 1);
    endtask

    task automatic send_frame(input int w, input int bad_start, input int bad_stop);
        send(bad_start);
        for (int i = DW - 1; i >= 0; i--) send((w >> i) & 1);
        send(1);
        send(bad_stop ? 0 : 1);
        send(1);
    endtask

    task automatic send_pattern(input int n, input int seed);
        int v;
        v = seed;
        for (int i = 0; i < n; i++) begin
            v = (v * 37 + 11) & 255;
            send((v >> 3) & 1);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R10 reset state
        do_reset();

        // Single device: count reaches length exactly at fill (R7)
        send_ones(3);
        send_header(72);
        send_ones(4);
        send_frame('hA5, 0, 0);
        send_frame('h3C, 0, 0);
        send_frame('hF0, 0, 0);
        send_pattern(20, 5);   // R9: data-out held high after start-up

        // Chain: surplus forwarded before start-up (R8)
        do_reset();
        send_pattern(12, 9);   // R1: junk while searching
        send_header(102);
        send_ones(4);
        send_frame('h81, 0, 0);
        send_frame('h7E, 0, 0);
        send_frame('h55, 0, 0);
        send_pattern(40, 3);

        // Bad stop bit then recovery (R6)
        do_reset();
        send_header(72);
        send_ones(4);
        send_frame('h12, 0, 0);
        send_frame('h34, 0, 1);
        send_pattern(10, 7);
        send_header(72);
        send_ones(4);
        send_frame('hC3, 0, 0);
        send_frame('h96, 0, 0);
        send_frame('h0F, 0, 0);
        send_ones(6);

        // Bad start bit on a later frame (R6)
        do_reset();
        send_header(90);
        send_ones(6);
        send_frame('hEE, 0, 0);
        send_frame('h11, 1, 0);
        send_ones(10);

        // Length already passed at fill: forwarding continues (R8)
        do_reset();
        send_header(40);
        send_ones(4);
        send_frame('h01, 0, 0);
        send_frame('h80, 0, 0);
        send_frame('hFF, 0, 0);
        send_pattern(30, 1);

        @(negedge cclk);
        #1;
        chk(dout_tag, dout, e_dout);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule